// File: doc/BRIEF.md
# GPIO Interrupt-on-Change Controller

This block watches an 8-pin (parameterizable) input port and raises an interrupt when an enabled pin either changes from the value it had one clock earlier or disagrees with a programmed reference value. Each pin selects its own trigger mode. When an interrupt is taken, a flag vector names the single pin responsible and a capture register freezes the whole port as it was sampled in that cycle. Both stay frozen until software clears the interrupt by reading the port or the capture register; which of the two reads clears it is a configuration bit.

The interrupt line goes to a pad. In push-pull mode it is driven at all times, with a programmable active level. In open-drain mode the pad is driven low only while the interrupt is pending and released otherwise; the polarity setting is then ignored. All configuration values and the two read strobes come from a register block elsewhere. The pin vector arrives already synchronized.

Control is a three-state machine. ST_PRIME is the single cycle after reset, in which the previous-value reference is loaded and nothing is detected. It always moves to ST_WATCH. ST_WATCH looks for triggers and moves to ST_HELD on the first one ("take"). ST_HELD keeps flags and capture frozen and returns to ST_WATCH on a clearing read ("release").

Top module: `gioc_top`

## Requirements
- R1: A pin whose bit in `irq_en_i` is 0 never causes an interrupt, in either trigger mode.
- R2: With `cmp_mode_i` bit = 0, an enabled pin triggers when `pin_i` differs from its value at the previous rising edge. The reference is refreshed every cycle. No trigger is evaluated in the first cycle after reset.
- R3: With `cmp_mode_i` bit = 1, an enabled pin triggers whenever `pin_i` differs from its `dflt_i` bit. If the mismatch remains after a clear, the interrupt is taken again at the next rising edge.
- R4: A change applied to `pin_i` becomes visible on `flag_o` after the first rising edge that samples it. `flag_o` then holds a one-hot vector with bit i set, where i is the lowest-numbered triggering pin, even when several pins trigger together. While no interrupt is pending, `flag_o` is 0.
- R5: In the cycle an interrupt is taken, `cap_o` loads `pin_i` as sampled at that edge.
- R6: While an interrupt is pending, `flag_o` and `cap_o` do not change. A change that happens only during the pending period is not reported afterwards.
- R7: With `clr_sel_i` = 0, a cycle with `rd_port_i` = 1 clears the pending interrupt. With `clr_sel_i` = 1, `rd_cap_i` does so instead, and the other strobe has no effect. Clearing sets `flag_o` to 0 and leaves `cap_o` unchanged.
- R8: With `int_od_i` = 0, `irq_oe_o` = 1 and `irq_o` equals `int_pol_i` while the interrupt is pending, and its inverse otherwise.
- R9: With `int_od_i` = 1, `irq_o` = 0 at all times and `irq_oe_o` = 1 only while the interrupt is pending, whatever the value of `int_pol_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | W | Synchronized pin levels |
| irq_en_i | input | W | Per-pin interrupt enable |
| cmp_mode_i | input | W | Per-pin mode: 0 = any change, 1 = compare with reference |
| dflt_i | input | W | Per-pin reference level for compare mode |
| clr_sel_i | input | 1 | 0 = port read clears, 1 = capture read clears |
| int_pol_i | input | 1 | Push-pull active level |
| int_od_i | input | 1 | Open-drain pad mode |
| rd_port_i | input | 1 | Port read strobe |
| rd_cap_i | input | 1 | Capture read strobe |
| flag_o | output | W | One-hot cause flag |
| cap_o | output | W | Port snapshot at interrupt time |
| irq_o | output | 1 | Interrupt pad data |
| irq_oe_o | output | 1 | Interrupt pad drive enable |

## Verification
The assertions check on every cycle that the flag is at most one-hot and nonzero exactly while pending, that flag and capture are frozen during a pending period without a clearing read, that a clearing read zeroes the flag on the next edge, that fully disabled pins keep the block idle, and that the pad encoding follows the pending state in both drive modes. Only the bench scenarios can show which pin is flagged and what value is captured for each of the 255 nonzero multi-pin change patterns. They also cover the re-fire after a clear across all 256 reference values in compare mode, the loss of changes made during a pending period, and the selection of the clearing strobe.

// File: rtl/gioc_pkg.sv
`timescale 1ns/1ps
package gioc_pkg;
    typedef enum logic [1:0] {
        ST_PRIME = 2'd0,
        ST_WATCH = 2'd1,
        ST_HELD  = 2'd2
    } gioc_state_e;
endpackage

// File: rtl/gioc_detect.sv
`timescale 1ns/1ps
// Per-pin trigger generation: previous-sample reference plus mode select.
module gioc_detect #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_i,
    input  logic [W-1:0] en_i,
    input  logic [W-1:0] mode_i,
    input  logic [W-1:0] dflt_i,
    output logic [W-1:0] trig_o
);
    logic [W-1:0] prev_q;

    // reference refreshed every cycle (R2)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= pin_i;
    end

    for (genvar i = 0; i < W; i++) begin : g_pin
        logic differs;
        always_comb begin
            if (mode_i[i]) differs = pin_i[i] ^ dflt_i[i];
            else           differs = pin_i[i] ^ prev_q[i];
            trig_o[i] = en_i[i] & differs;
        end
    end
endmodule

// File: rtl/gioc_pick.sv
`timescale 1ns/1ps
// Lowest-index priority select producing a one-hot cause vector.
module gioc_pick #(
    parameter int W = 8
) (
    input  logic [W-1:0] trig_i,
    output logic [W-1:0] onehot_o,
    output logic         any_o
);
    logic [W:0] seen;

    assign seen[0] = 1'b0;
    for (genvar i = 0; i < W; i++) begin : g_chain
        assign onehot_o[i] = trig_i[i] & ~seen[i];
        assign seen[i+1]   = seen[i] | trig_i[i];
    end
    assign any_o = seen[W];
endmodule

// File: rtl/gioc_pad.sv
`timescale 1ns/1ps
// Interrupt pad encoding: push-pull with polarity, or open-drain pull-low.
module gioc_pad (
    input  logic active_i,
    input  logic pol_i,
    input  logic od_i,
    output logic irq_o,
    output logic irq_oe_o
);
    always_comb begin
        if (od_i) begin
            irq_o    = 1'b0;
            irq_oe_o = active_i;
        end else begin
            irq_o    = active_i ? pol_i : ~pol_i;
            irq_oe_o = 1'b1;
        end
    end
endmodule

// File: rtl/gioc_top.sv
`timescale 1ns/1ps
module gioc_top #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_i,
    input  logic [W-1:0] irq_en_i,
    input  logic [W-1:0] cmp_mode_i,
    input  logic [W-1:0] dflt_i,
    input  logic         clr_sel_i,
    input  logic         int_pol_i,
    input  logic         int_od_i,
    input  logic         rd_port_i,
    input  logic         rd_cap_i,
    output logic [W-1:0] flag_o,
    output logic [W-1:0] cap_o,
    output logic         irq_o,
    output logic         irq_oe_o
);
    import gioc_pkg::*;

    gioc_state_e  state_q, state_d;
    logic [W-1:0] trig, pick;
    logic         any_trig, clear_hit, held;

    gioc_detect #(.W(W)) u_detect (
        .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .en_i(irq_en_i),
        .mode_i(cmp_mode_i), .dflt_i(dflt_i), .trig_o(trig)
    );

    gioc_pick #(.W(W)) u_pick (
        .trig_i(trig), .onehot_o(pick), .any_o(any_trig)
    );

    assign clear_hit = clr_sel_i ? rd_cap_i : rd_port_i;  // R7
    assign held      = (state_q == ST_HELD);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_PRIME;
        else        state_q <= state_d;
    end

    // transitions: prime -> watch, take, release
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_PRIME: state_d = ST_WATCH;
            ST_WATCH: if (any_trig)  state_d = ST_HELD;
            ST_HELD:  if (clear_hit) state_d = ST_WATCH;
            default:  state_d = ST_PRIME;
        endcase
    end

    // flag and capture registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_o <= '0;
            cap_o  <= '0;
        end else begin
            unique case (state_q)
                ST_WATCH: if (any_trig) begin
                    flag_o <= pick;   // R4
                    cap_o  <= pin_i;  // R5
                end
                ST_HELD: if (clear_hit) flag_o <= '0;
                default: ;
            endcase
        end
    end

    gioc_pad u_pad (
        .active_i(held), .pol_i(int_pol_i), .od_i(int_od_i),
        .irq_o(irq_o), .irq_oe_o(irq_oe_o)
    );
endmodule

// File: rtl/gioc_chk.sv
`timescale 1ns/1ps
module gioc_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         held,
    input logic [W-1:0] flag_o,
    input logic [W-1:0] cap_o,
    input logic [W-1:0] irq_en_i,
    input logic         clr_sel_i,
    input logic         rd_port_i,
    input logic         rd_cap_i,
    input logic         int_pol_i,
    input logic         int_od_i,
    input logic         irq_o,
    input logic         irq_oe_o
);
    logic clr_now;
    assign clr_now = clr_sel_i ? rd_cap_i : rd_port_i;

    a_r4_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(flag_o));
    a_r4_flag_tracks_pending: assert property (@(posedge clk) disable iff (!rst_n)
        held == (flag_o != '0));
    a_r6_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        held && !clr_now |=> $stable(flag_o) && $stable(cap_o));
    a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
        held && clr_now |=> flag_o == '0 && $stable(cap_o));
    a_r1_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        !held && irq_en_i == '0 |=> !held);
    a_r8_push_pull: assert property (@(posedge clk) disable iff (!rst_n)
        !int_od_i |-> irq_oe_o && (irq_o == (held ? int_pol_i : !int_pol_i)));
    a_r9_open_drain: assert property (@(posedge clk) disable iff (!rst_n)
        int_od_i |-> !irq_o && (irq_oe_o == held));
endmodule

bind gioc_top gioc_chk #(.W(W)) u_chk (
    .clk(clk), .rst_n(rst_n), .held(held), .flag_o(flag_o), .cap_o(cap_o),
    .irq_en_i(irq_en_i), .clr_sel_i(clr_sel_i), .rd_port_i(rd_port_i),
    .rd_cap_i(rd_cap_i), .int_pol_i(int_pol_i), .int_od_i(int_od_i),
    .irq_o(irq_o), .irq_oe_o(irq_oe_o)
);

// File: tb/sim_gioc_top.sv
`timescale 1ns/1ps
module sim_gioc_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] pin = '0, en = '0, mode = '0, dflt = '0;
    logic       clr_sel = 1'b0, pol = 1'b0, od = 1'b0, rd_port = 1'b0, rd_cap = 1'b0;
    logic [7:0] flag, cap;
    logic       irq, irq_oe;
    int         n_chk = 0, n_bad = 0;

    always #2.5 clk = ~clk;

    gioc_top #(.W(8)) u0 (
        .clk(clk), .rst_n(rst_n), .pin_i(pin), .irq_en_i(en), .cmp_mode_i(mode),
        .dflt_i(dflt), .clr_sel_i(clr_sel), .int_pol_i(pol), .int_od_i(od),
        .rd_port_i(rd_port), .rd_cap_i(rd_cap), .flag_o(flag), .cap_o(cap),
        .irq_o(irq), .irq_oe_o(irq_oe)
    );

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input logic ok, input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    // pad expectation as {irq, oe}
    function automatic logic [7:0] pad_exp(input logic act);
        if (od) return {6'b0, 1'b0, act};
        return {6'b0, act ? pol : ~pol, 1'b1};
    endfunction

    task automatic chk_state(input string req, input logic [7:0] ef, input logic [7:0] ec);
        chk(flag == ef, {req, " flag"}, flag, ef);
        chk(cap == ec,  {req, " cap"},  cap, ec);
        chk({6'b0, irq, irq_oe} == pad_exp(ef != 0), {req, " pad"}, {6'b0, irq, irq_oe}, pad_exp(ef != 0));
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    endtask

    function automatic logic [7:0] low1(input logic [7:0] v);
        return v & (~v + 8'd1);
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=00 expected=01");
        summary();
        $finish;
    end

    initial begin
        logic [7:0] last_cap;
        // reset state
        @(negedge clk); @(negedge clk);
        chk_state("R4 reset", 8'h00, 8'h00);
        rst_n = 1'b1;
        step(); step();
        chk_state("R2 after prime", 8'h00, 8'h00);

        // R1: disabled pins ignored
        pin = 8'hFF; step();
        chk_state("R1 toggle high", 8'h00, 8'h00);
        pin = 8'h00; step(); step();
        chk_state("R1 toggle low", 8'h00, 8'h00);
        en = 8'hFF; step(); step();
        chk_state("R1 enable stable", 8'h00, 8'h00);

        // R2/R4/R5: every nonzero change pattern in change mode
        for (int v = 1; v < 256; v++) begin
            pin = v[7:0]; step();
            chk_state("R4 R5 pattern", low1(v[7:0]), v[7:0]);
            pin = 8'h00; rd_port = 1'b1; step();
            rd_port = 1'b0;
            chk_state("R7 port clear", 8'h00, v[7:0]);
            step();
            chk_state("R6 lost change", 8'h00, v[7:0]);
        end

        // R6: frozen while pending
        pin = 8'h04; step();
        chk_state("R6 take", 8'h04, 8'h04);
        pin = 8'h01; step(); step();
        chk_state("R6 frozen", 8'h04, 8'h04);
        rd_port = 1'b1; step(); rd_port = 1'b0;
        chk_state("R6 cleared", 8'h00, 8'h04);
        step();
        chk_state("R6 no replay", 8'h00, 8'h04);
        pin = 8'h00; step();
        chk_state("R2 change back", 8'h01, 8'h00);
        rd_port = 1'b1; step(); rd_port = 1'b0; step();

        // R7: clearing strobe selection
        pin = 8'h10; step();
        chk_state("R7 take a", 8'h10, 8'h10);
        rd_cap = 1'b1; step(); rd_cap = 1'b0;
        chk_state("R7 cap read ignored", 8'h10, 8'h10);
        rd_port = 1'b1; step(); rd_port = 1'b0;
        chk_state("R7 port read clears", 8'h00, 8'h10);
        clr_sel = 1'b1;
        pin = 8'h00; step();
        chk_state("R7 take b", 8'h10, 8'h00);
        rd_port = 1'b1; step(); rd_port = 1'b0;
        chk_state("R7 port read ignored", 8'h10, 8'h00);
        rd_cap = 1'b1; step(); rd_cap = 1'b0;
        chk_state("R7 cap read clears", 8'h00, 8'h00);
        clr_sel = 1'b0; step();

        // R8/R9: pad encodings, pending via compare mode on pin 0
        mode = 8'hFF; en = 8'h01; dflt = 8'h00; step();
        for (int k = 0; k < 4; k++) begin
            od = k[1]; pol = k[0]; step();
            chk_state(od ? "R9 idle" : "R8 idle", 8'h00, 8'h00);
            dflt = 8'h01; step();
            chk_state(od ? "R9 active" : "R8 active", 8'h01, 8'h00);
            dflt = 8'h00; rd_port = 1'b1; step(); rd_port = 1'b0;
            chk_state(od ? "R9 released" : "R8 released", 8'h00, 8'h00);
        end
        od = 1'b0; pol = 1'b0;

        // R3: compare mode across all references, with re-fire
        en = 8'hFF; pin = 8'h5A; dflt = 8'h5A; step(); step();
        chk_state("R3 match idle", 8'h00, 8'h00);
        last_cap = 8'h00;
        for (int d = 0; d < 256; d++) begin
            dflt = d[7:0]; step();
            if (d[7:0] == 8'h5A) begin
                chk_state("R3 no mismatch", 8'h00, last_cap);
            end else begin
                chk_state("R3 mismatch", low1(d[7:0] ^ 8'h5A), 8'h5A);
                last_cap = 8'h5A;
                rd_port = 1'b1; step(); rd_port = 1'b0;
                chk_state("R3 cleared", 8'h00, 8'h5A);
                step();
                chk_state("R3 refire", low1(d[7:0] ^ 8'h5A), 8'h5A);
                dflt = 8'h5A; rd_port = 1'b1; step(); rd_port = 1'b0;
                step();
                chk_state("R3 settled", 8'h00, 8'h5A);
            end
        end

        summary();
        $finish;
    end
endmodule